// File: doc/BRIEF.md
# RF Enable Transmission Sequencer

This block runs one button-triggered burst of code words for an external transmitter. When a button becomes active it waits out a power-up delay, raises the RF enable output, waits for the transmitter's PLL to settle, and then asks a separate serialiser to send code words one at a time. It pulses a start strobe for each word and waits for the serialiser's word-done strobe. Between words it holds a guard gap.

Words repeat while the button is held. After release, the burst still runs up to a configured minimum word count. A programmable time-out caps the burst in every case. When the last word ends, the enable stays high for one guard time and then drops. If the burst ended because of the time-out, the block then requests shutdown.

All delays are counted in ticks of an external time base. `TICKS_PER_100US` gives the number of ticks in 100 µs. The power-up and PLL delays are parameters in ticks. The configuration inputs must stay stable for the whole burst.

Top module: `rfen_burst_seq`

## Requirements
- R1: From idle, the first clock edge that samples `btn_i` high starts the power-up delay, with `rf_en_o` low. `rf_en_o` goes high on the edge that counts the `PWRUP_TICKS`-th time-base tick after that.
- R2: `word_start_o` first pulses on the edge that counts the `PLL_TICKS`-th tick after `rf_en_o` rises. It is never high in the cycle where `rf_en_o` rises.
- R3: `word_start_o` is a one-cycle pulse and is only ever high while `rf_en_o` is high. After a word-done that continues the burst, the next start follows one guard time later.
- R4: `min_words_i` code n (0..3) gives a minimum of 2^n words (1, 2, 4, 8). This many words are sent even when the button is released after the first clock edge.
- R5: `guard_sel_i` sets the guard time in ticks. Code 0 is one TE. Codes 1, 2 and 3 are 64, 256 and 768 units of `TICKS_PER_100US`, each plus 2 TE.
- R6: `rate_sel_i` code r sets TE to `TICKS_PER_100US` << r ticks, meaning 100, 200, 400 or 800 µs.
- R7: `tmo_sel_i` code 0 disables the time-out. Codes 1, 2 and 3 give 8000, 32000 and 256000 units of `TICKS_PER_100US`, counted from the start of power-up. Once the time-out has expired, no new word starts, even if the minimum word count is not yet reached. The enable drops one guard time after the last word ends, and `shutdown_o` then goes high with `rf_en_o` low.
- R8: `shutdown_o` stays high while `btn_i` is high. On the first edge that samples `btn_i` low it clears and the block returns to idle.
- R9: While the button is held and no time-out has occurred, words keep repeating. The button level is only sampled in the cycle `word_done_i` is high.
- R10: During reset and immediately after it, `rf_en_o`, `word_start_o` and `shutdown_o` are low.
- R11: When the burst ends without a time-out, `rf_en_o` falls on the edge that counts the guard time after the final word-done. The block returns to idle without raising `shutdown_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick strobe |
| btn_i | input | 1 | Button active (already debounced) |
| min_words_i | input | 2 | Minimum word count code |
| guard_sel_i | input | 2 | Guard time code |
| tmo_sel_i | input | 2 | Time-out code |
| rate_sel_i | input | 2 | Element time code |
| word_done_i | input | 1 | Serialiser finished the current word |
| rf_en_o | output | 1 | Transmitter enable |
| word_start_o | output | 1 | Start strobe for the next word |
| shutdown_o | output | 1 | Shutdown request after time-out |

## Verification
Two events can fall in the same cycle: the time-out expiring and a word boundary, where a release or minimum-count decision is made. The bench provokes this by running long words against the shortest time-out with an eight-word minimum, so that the expiry lands while a word or a gap is in flight. A cycle-accurate reference model in the bench decides whether a further start may follow. Every clock is compared against that model, and the word count is checked to be below the minimum, with shutdown seen afterwards.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_PLL,
        ST_START,
        ST_WAIT,
        ST_GAP,
        ST_TAIL,
        ST_SHUT
    } seq_state_e;

endpackage

// File: rtl/rfseq_timing.sv
module rfseq_timing #(
    parameter int unsigned TICKS_PER_100US = 1,
    parameter int unsigned GW = 10,
    parameter int unsigned TW = 18
) (
    input  logic [1:0]    rate_sel_i,
    input  logic [1:0]    guard_sel_i,
    input  logic [1:0]    tmo_sel_i,
    input  logic [1:0]    min_sel_i,
    output logic [GW-1:0] guard_ticks_o,
    output logic [TW-1:0] tmo_ticks_o,
    output logic          tmo_en_o,
    output logic [3:0]    min_words_o
);

    localparam logic [GW-1:0] UNIT  = GW'(TICKS_PER_100US);
    localparam logic [GW-1:0] GBASE1 = GW'(64 * TICKS_PER_100US);
    localparam logic [GW-1:0] GBASE2 = GW'(256 * TICKS_PER_100US);
    localparam logic [GW-1:0] GBASE3 = GW'(768 * TICKS_PER_100US);
    localparam logic [TW-1:0] TLIM1 = TW'(8000 * TICKS_PER_100US);
    localparam logic [TW-1:0] TLIM2 = TW'(32000 * TICKS_PER_100US);
    localparam logic [TW-1:0] TLIM3 = TW'(256000 * TICKS_PER_100US);

    logic [GW-1:0] te;

    always_comb begin
        te = UNIT << rate_sel_i;
        unique case (guard_sel_i)
            2'd0:    guard_ticks_o = te;
            2'd1:    guard_ticks_o = GBASE1 + (te << 1);
            2'd2:    guard_ticks_o = GBASE2 + (te << 1);
            default: guard_ticks_o = GBASE3 + (te << 1);
        endcase
        tmo_en_o = (tmo_sel_i != 2'd0);
        unique case (tmo_sel_i)
            2'd1:    tmo_ticks_o = TLIM1;
            2'd2:    tmo_ticks_o = TLIM2;
            2'd3:    tmo_ticks_o = TLIM3;
            default: tmo_ticks_o = '0;
        endcase
        min_words_o = 4'd1 << min_sel_i;
    end

endmodule

// File: rtl/rfseq_tmo.sv
module rfseq_tmo #(
    parameter int unsigned TW = 18
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          hit;
    } tmo_t;

    tmo_t tmo_d, tmo_q;

    always_comb begin
        tmo_d = tmo_q;
        if (clr_i) begin
            tmo_d = '0;
        end else if (run_i && tick_i && !tmo_q.hit) begin
            tmo_d.cnt = tmo_q.cnt + 1'b1;
            if (en_i && (tmo_d.cnt == limit_i)) begin
                tmo_d.hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmo_q <= '0;
        end else begin
            tmo_q <= tmo_d;
        end
    end

    assign expired_o = tmo_q.hit;

endmodule

// File: rtl/rfen_burst_seq.sv
module rfen_burst_seq
    import rfseq_pkg::*;
#(
    parameter int unsigned TICKS_PER_100US = 1,
    parameter int unsigned PWRUP_TICKS = 16,
    parameter int unsigned PLL_TICKS = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       btn_i,
    input  logic [1:0] min_words_i,
    input  logic [1:0] guard_sel_i,
    input  logic [1:0] tmo_sel_i,
    input  logic [1:0] rate_sel_i,
    input  logic       word_done_i,
    output logic       rf_en_o,
    output logic       word_start_o,
    output logic       shutdown_o
);

    localparam int unsigned GUARD_MAX = (768 + 16) * TICKS_PER_100US;
    localparam int unsigned GW = $clog2(GUARD_MAX + 1);
    localparam int unsigned TMO_MAX = 256000 * TICKS_PER_100US;
    localparam int unsigned TW = $clog2(TMO_MAX + 1);
    localparam int unsigned DLY_MAX = (PWRUP_TICKS > PLL_TICKS) ? PWRUP_TICKS : PLL_TICKS;
    localparam int unsigned DW = $clog2(DLY_MAX + 1);
    localparam int unsigned CW = (GW > DW) ? GW : DW;
    localparam logic [CW-1:0] PWRUP_LIM = CW'(PWRUP_TICKS);
    localparam logic [CW-1:0] PLL_LIM = CW'(PLL_TICKS);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic [3:0]    words;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [GW-1:0] guard_ticks;
    logic [TW-1:0] tmo_ticks;
    logic          tmo_en;
    logic [3:0]    min_words;
    logic          tmo_exp;
    logic [CW-1:0] lim;
    logic          span_end;
    logic [3:0]    words_nx;

    rfseq_timing #(
        .TICKS_PER_100US(TICKS_PER_100US),
        .GW(GW),
        .TW(TW)
    ) u_timing (
        .rate_sel_i   (rate_sel_i),
        .guard_sel_i  (guard_sel_i),
        .tmo_sel_i    (tmo_sel_i),
        .min_sel_i    (min_words_i),
        .guard_ticks_o(guard_ticks),
        .tmo_ticks_o  (tmo_ticks),
        .tmo_en_o     (tmo_en),
        .min_words_o  (min_words)
    );

    rfseq_tmo #(
        .TW(TW)
    ) u_tmo (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (seq_q.st == ST_IDLE),
        .run_i    ((seq_q.st != ST_IDLE) && (seq_q.st != ST_SHUT)),
        .tick_i   (tick_i),
        .en_i     (tmo_en),
        .limit_i  (tmo_ticks),
        .expired_o(tmo_exp)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_PWRUP: lim = PWRUP_LIM;
            ST_PLL:   lim = PLL_LIM;
            default:  lim = CW'(guard_ticks);
        endcase
        span_end = tick_i && ((seq_q.cnt + 1'b1) == lim);
        words_nx = (seq_q.words == 4'd8) ? 4'd8 : seq_q.words + 4'd1;

        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.cnt   = '0;
                seq_d.words = '0;
                if (btn_i) begin
                    seq_d.st = ST_PWRUP;
                end
            end
            ST_PWRUP: begin
                if (span_end) begin
                    seq_d.st  = ST_PLL;
                    seq_d.cnt = '0;
                end else if (tick_i) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_PLL: begin
                if (span_end) begin
                    seq_d.st  = ST_START;
                    seq_d.cnt = '0;
                end else if (tick_i) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_START: begin
                seq_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (word_done_i) begin
                    seq_d.words = words_nx;
                    seq_d.cnt   = '0;
                    if (!tmo_exp && (btn_i || (words_nx < min_words))) begin
                        seq_d.st = ST_GAP;
                    end else begin
                        seq_d.st = ST_TAIL;
                    end
                end
            end
            ST_GAP: begin
                if (span_end) begin
                    seq_d.cnt = '0;
                    seq_d.st  = tmo_exp ? ST_SHUT : ST_START;
                end else if (tick_i) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_TAIL: begin
                if (span_end) begin
                    seq_d.cnt = '0;
                    seq_d.st  = tmo_exp ? ST_SHUT : ST_IDLE;
                end else if (tick_i) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                if (!btn_i) begin
                    seq_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, words: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rf_en_o = (seq_q.st == ST_PLL) || (seq_q.st == ST_START) || (seq_q.st == ST_WAIT)
                  || (seq_q.st == ST_GAP) || (seq_q.st == ST_TAIL);
    assign word_start_o = (seq_q.st == ST_START);
    assign shutdown_o   = (seq_q.st == ST_SHUT);

endmodule

// File: rtl/rfseq_chk.sv
module rfseq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic btn_i,
    input logic rf_en_o,
    input logic word_start_o,
    input logic shutdown_o
);

    p_start_in_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_start_o |-> rf_en_o);

    p_start_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_start_o |=> !word_start_o);

    p_pll_before_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rf_en_o) |-> !word_start_o);

    p_shut_en_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shutdown_o |-> !rf_en_o);

    p_shut_after_burst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(shutdown_o) |-> $past(rf_en_o));

    p_shut_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shutdown_o && btn_i) |=> shutdown_o);

    p_shut_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shutdown_o && !btn_i) |=> !shutdown_o);

endmodule

bind rfen_burst_seq rfseq_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .btn_i       (btn_i),
    .rf_en_o     (rf_en_o),
    .word_start_o(word_start_o),
    .shutdown_o  (shutdown_o)
);

// File: tb/tb_rfen_burst_seq.sv
module tb_rfen_burst_seq;

    localparam int PW = 16;
    localparam int PL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic btn = 1'b0;
    logic wdone = 1'b0;
    logic [1:0] min_sel = 2'd0;
    logic [1:0] g_sel = 2'd0;
    logic [1:0] t_sel = 2'd0;
    logic [1:0] r_sel = 2'd0;
    logic en, st, sd;

    always #10 clk = ~clk;

    rfen_burst_seq #(
        .TICKS_PER_100US(1),
        .PWRUP_TICKS(PW),
        .PLL_TICKS(PL)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .btn_i(btn),
        .min_words_i(min_sel), .guard_sel_i(g_sel), .tmo_sel_i(t_sel),
        .rate_sel_i(r_sel), .word_done_i(wdone),
        .rf_en_o(en), .word_start_o(st), .shutdown_o(sd)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int word_len = 20;
    int tick_div = 1;
    int tick_ph = 0;
    int wcnt = 0;
    int nst = 0;
    int t_press = 0, t_en_rise = 0, t_en_fall = 0, t_first = 0, t_done = 0, last_gap = 0, t_sd = 0;
    bit seen_sd = 0;
    bit en_prev = 0;
    bit finished = 0;

    // reference model: phase 0 idle,1 power-up,2 settle,3 start,4 word,5 gap,6 tail,7 shutdown
    int mph = 0, mcnt = 0, mwords = 0, mtc = 0;
    bit mtf = 0;

    function automatic int guard_len(input int sel, input int rate);
        int te;
        te = 1 << rate;
        case (sel)
            0: return te;
            1: return 64 + 2 * te;
            2: return 256 + 2 * te;
            default: return 768 + 2 * te;
        endcase
    endfunction

    function automatic int tmo_len(input int sel);
        case (sel)
            1: return 8000;
            2: return 32000;
            3: return 256000;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        finished = 1;
        $finish;
    endtask

    always @(posedge clk) begin
        int g, nph;
        if (!rst_n) begin
            mph = 0; mcnt = 0; mwords = 0; mtc = 0; mtf = 0;
        end else begin
            g = guard_len(g_sel, r_sel);
            nph = mph;
            case (mph)
                0: begin mcnt = 0; mwords = 0; if (btn) nph = 1; end
                1: if (tick) begin mcnt++; if (mcnt == PW) begin mcnt = 0; nph = 2; end end
                2: if (tick) begin mcnt++; if (mcnt == PL) begin mcnt = 0; nph = 3; end end
                3: nph = 4;
                4: if (wdone) begin
                       mwords++;
                       mcnt = 0;
                       nph = (!mtf && (btn || mwords < (1 << min_sel))) ? 5 : 6;
                   end
                5: if (tick) begin mcnt++; if (mcnt == g) begin mcnt = 0; nph = mtf ? 7 : 3; end end
                6: if (tick) begin mcnt++; if (mcnt == g) begin mcnt = 0; nph = mtf ? 7 : 0; end end
                default: if (!btn) nph = 0;
            endcase
            if (mph == 0) begin
                mtc = 0; mtf = 0;
            end else if (mph != 7 && tick && !mtf) begin
                mtc++;
                if (tmo_len(t_sel) > 0 && mtc == tmo_len(t_sel)) mtf = 1;
            end
            mph = nph;
        end
    end

    always @(negedge clk) begin
        bit xe, xs, xd;
        cyc++;
        if (rst_n) begin
            xe = (mph >= 2 && mph <= 6);
            xs = (mph == 3);
            xd = (mph == 7);
            checks++;
            if (en !== xe || st !== xs || sd !== xd) begin
                fails++;
                $display("FAIL R1 R3 R7 model cycle %0d actual en/start/shut=%b%b%b expected=%b%b%b",
                         cyc, en, st, sd, xe, xs, xd);
            end
        end
        if (en && !en_prev) t_en_rise = cyc;
        if (!en && en_prev) t_en_fall = cyc;
        if (st) begin
            nst++;
            if (nst == 1) t_first = cyc;
            else last_gap = cyc - t_done;
        end
        if (sd && !seen_sd) begin seen_sd = 1; t_sd = cyc; end
        en_prev = en;
        wdone = 1'b0;
        if (st) wcnt = word_len;
        else if (wcnt > 0) begin
            wcnt--;
            if (wcnt == 0) begin wdone = 1'b1; t_done = cyc; end
        end
        tick_ph++;
        if (tick_ph >= tick_div) tick_ph = 0;
        tick = (tick_ph == 0);
        if (cyc > 190000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            summary();
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // hold < 0: keep pressed until shutdown; hold == 0: one-cycle press; else release after that many starts
    task automatic burst(input int mn, input int gs, input int ts, input int rs, input int hold, input int wl);
        min_sel = 2'(mn); g_sel = 2'(gs); t_sel = 2'(ts); r_sel = 2'(rs);
        word_len = wl;
        step();
        nst = 0; seen_sd = 0;
        btn = 1'b1;
        t_press = cyc;
        step();
        if (hold == 0) begin
            btn = 1'b0;
        end else if (hold > 0) begin
            while (nst < hold) step();
            btn = 1'b0;
        end
        if (hold < 0 || ts != 0) begin
            while (!seen_sd && !(t_en_fall > t_press && !en && hold >= 0 && ts == 0)) step();
        end else begin
            while (!(t_en_fall > t_press)) step();
        end
    endtask

    initial begin
        repeat (3) step();
        chk("R10 en in reset", int'(en), 0);
        chk("R10 start in reset", int'(st), 0);
        chk("R10 shut in reset", int'(sd), 0);
        rst_n = 1'b1;
        step();
        chk("R10 en after reset", int'(en), 0);

        // single word, shortest guard
        burst(0, 0, 0, 0, 0, 20);
        chk("R4 one word", nst, 1);
        chk("R1 power-up delay", t_en_rise - t_press, PW + 1);
        chk("R2 settle delay", t_first - t_en_rise, PL);
        chk("R11 tail", t_en_fall - t_done, guard_len(0, 0) + 1);
        chk("R11 no shutdown", int'(seen_sd), 0);
        repeat (5) step();

        burst(2, 1, 0, 1, 0, 20);
        chk("R4 four words", nst, 4);
        chk("R5 guard code 1", last_gap, 69);
        chk("R11 tail guard code 1", t_en_fall - t_done, 69);
        repeat (5) step();

        burst(1, 0, 0, 3, 0, 20);
        chk("R4 two words", nst, 2);
        chk("R6 TE 800us", last_gap, 9);
        repeat (5) step();

        burst(3, 2, 0, 0, 0, 20);
        chk("R4 eight words", nst, 8);
        chk("R5 guard code 2", last_gap, 259);
        repeat (5) step();

        burst(0, 0, 0, 2, 5, 20);
        chk("R9 held five words", nst, 5);
        chk("R6 TE 400us", last_gap, 5);
        repeat (5) step();

        // held until the 0.8 s time-out
        burst(0, 0, 1, 0, -1, 20);
        chk("R7 shutdown seen", int'(seen_sd), 1);
        chk("R7 en low in shutdown", int'(en), 0);
        chk("R7 time-out not early", int'(t_sd - t_press >= 8000), 1);
        chk("R9 words repeated", int'(nst > 8), 1);
        repeat (4) step();
        chk("R8 shutdown held", int'(sd), 1);
        btn = 1'b0;
        step();
        step();
        chk("R8 shutdown cleared", int'(sd), 0);
        repeat (5) step();

        // time-out lands on or near a word boundary and caps the minimum count
        burst(3, 3, 1, 3, 0, 400);
        chk("R7 minimum capped", int'(nst < 8), 1);
        chk("R7 capped shutdown", int'(seen_sd), 1);
        step();
        step();
        chk("R8 released shutdown drops", int'(sd), 0);
        repeat (5) step();

        // slower time base
        tick_div = 3;
        burst(1, 0, 0, 1, 0, 20);
        chk("R1 slow tick two words", nst, 2);
        tick_div = 1;
        repeat (10) step();

        burst(0, 0, 2, 0, -1, 20);
        chk("R7 time-out code 2", int'(t_sd - t_press >= 32000), 1);
        btn = 1'b0;
        repeat (3) step();
        chk("R8 idle after release", int'(sd | en), 0);

        summary();
    end

endmodule